// File: doc/BRIEF.md
# Keyed Watchdog Control Unit

This block is a watchdog timer whose configuration is guarded twice. First, the control word accepts writes only while the protection-release input `prot_lift` is high. Writes made while it is low are dropped without trace. Second, every accepted write must carry the check pattern `101` in a three-bit field. A write that omits the pattern is treated as tampering and fires the reset output at once.

A prescaler divides the clock by a base ratio, and then by a selectable power of two, to make a tick. An up-counter advances on each tick. When the counter wraps, the block drives a fixed-width reset pulse and sets a sticky flag. Software keeps the timer alive by writing the byte pair 0x55 then 0xAA to a separate key address. It can stop the timer with a disable bit, and it clears the flag by writing 1 to the flag bit.

The main state machine has three states:
- `WD_RUN`: counting.
- `WD_OFF`: disabled, counter held at zero.
- `WD_BITE`: reset pulse active.

Its transitions are:
- RUN→BITE on overflow.
- any→BITE on a bad-pattern write, which also restarts the pulse window.
- RUN→OFF on a valid write with disable=1.
- OFF→RUN on a valid write with disable=0.
- BITE→RUN or BITE→OFF when the pulse ends, chosen by the disable bit.

The key sequencer has two states:
- `KEY_IDLE`: 0x55 moves it to KEY_ARMED.
- `KEY_ARMED`: 0xAA services the timer and returns to KEY_IDLE, 0x55 stays in KEY_ARMED, and any other byte returns to KEY_IDLE.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `wd_reset` and `wd_flag` are 0, the timer is enabled (state WD_RUN) with prescale code 0, and the counter and prescaler are zero.
- R2: A write to the control address lands only when `prot_lift`=1 and bits [5:3] equal 3'b101. With `prot_lift`=0, a control write changes nothing and never fires the reset, whatever its content.
- R3: A control write with `prot_lift`=1 and bits [5:3] not equal to 3'b101 leaves the control word unchanged. It drives `wd_reset` high from the cycle after the write for exactly 8 cycles.
- R4: The control word has bit 7 as the flag, bit 6 as disable, bits [5:3] as the check field and bits [2:0] as the prescale code. The tick period is BASE_DIV clocks for codes 0 and 1, and BASE_DIV·2^(code−1) clocks for codes 2..7.
- R5: The CNT_W-bit counter advances once per tick. After 2^CNT_W ticks it wraps, `wd_reset` pulses for 8 cycles and `wd_flag` sets in the same cycle the pulse starts. Counting restarts from zero when the pulse ends.
- R6: With disable (bit 6) set by a valid write, the counter and prescaler hold at zero and no overflow occurs. A valid write with disable=0 resumes counting from zero.
- R7: `wd_flag` clears only on a valid control write with bit 7 = 1. A valid write with bit 7 = 0 leaves it set.
- R8: At the key address (1), the byte 0x55 followed by 0xAA clears the counter and prescaler. Repeated 0x55 bytes keep the sequence armed. A lone 0xAA, or 0xAA after an intervening other byte, has no effect.
- R9: A bad-pattern write during a reset pulse restarts the 8-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 = control word, 1 = key register |
| wr_data | input | 8 | Write data |
| prot_lift | input | 1 | High while control-word protection is released |
| wd_reset | output | 1 | Watchdog reset pulse |
| wd_flag | output | 1 | Sticky overflow flag |

## Verification
Writes are captured at a clock edge, and `wd_reset` follows that edge directly: it is high at the first sample after a bad-pattern write and stays high for 8 samples. A service or enable write leaves the counter and prescaler at zero. Overflow then becomes visible exactly period·2^CNT_W samples later, where period is the tick period in clocks. The bench therefore checks `wd_reset` one sample before that point (expecting low) and at that point (expecting high). The flag is checked in the same sample the pulse starts. All sampling is on the falling edge, and cycle counts run from the sample that follows the write.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        WD_RUN  = 2'd0,
        WD_OFF  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic       flag;
        logic       dis;
        logic [2:0] chk;
        logic [2:0] ps;
    } ctrl_word_t;

    localparam logic [2:0] CHECK_PATTERN = 3'b101;
    localparam logic [7:0] KEY_FIRST     = 8'h55;
    localparam logic [7:0] KEY_SECOND    = 8'hAA;

endpackage

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
    parameter int BASE_DIV = 512,
    parameter int PS_W     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int MAX_SHIFT = (1 << PS_W) - 2;
    localparam int DIV_MAX   = BASE_DIV << MAX_SHIFT;
    localparam int CW        = $clog2(DIV_MAX + 1);

    logic [CW-1:0]   div_cnt;
    logic [CW-1:0]   div_lim;
    logic [PS_W-1:0] shamt;

    always_comb begin
        shamt   = (ps == '0) ? '0 : ps - PS_W'(1);
        div_lim = (CW'(BASE_DIV) << shamt) - CW'(1);
        tick    = run && (div_cnt >= div_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_cnt <= '0;
        else if (clr || !run)   div_cnt <= '0;
        else if (tick)          div_cnt <= '0;
        else                    div_cnt <= div_cnt + CW'(1);
    end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick,
    output logic             ovf,
    output logic [CNT_W-1:0] cnt
);
    assign ovf = tick && (cnt == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clr || !run) cnt <= '0;
        else if (tick)        cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/wdk_key_fsm.sv
module wdk_key_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       service
);
    import wdk_pkg::*;

    key_state_e key_q, key_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= KEY_IDLE;
        else        key_q <= key_d;
    end

    always_comb begin
        key_d = key_q;
        if (key_wr) begin
            unique case (key_q)
                KEY_IDLE:  key_d = (key_data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: key_d = (key_data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                default:   key_d = KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        service = key_wr && (key_q == KEY_ARMED) && (key_data == KEY_SECOND);
    end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int ADDR_W      = 2,
    parameter int CTRL_ADDR   = 0,
    parameter int KEY_ADDR    = 1,
    parameter int BASE_DIV    = 512,
    parameter int CNT_W       = 8,
    parameter int BITE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prot_lift,
    output logic              wd_reset,
    output logic              wd_flag
);
    import wdk_pkg::*;

    localparam int HOLD_W = $clog2(BITE_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(BITE_CYCLES - 1);

    ctrl_word_t  wr_word;
    logic        ctrl_hit, ctrl_take, ctrl_bad, key_wr, service;
    logic [2:0]  ps_q;
    logic        dis_q, dis_d, flag_q;
    logic        run, tick, ovf;
    logic [CNT_W-1:0] cnt_q;
    wd_state_e   state_q, state_d;
    logic [HOLD_W-1:0] hold_q, hold_d;

    always_comb begin
        wr_word   = ctrl_word_t'(wr_data);
        ctrl_hit  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && prot_lift;
        ctrl_take = ctrl_hit && (wr_word.chk == CHECK_PATTERN);
        ctrl_bad  = ctrl_hit && (wr_word.chk != CHECK_PATTERN);
        key_wr    = wr_en && (wr_addr == ADDR_W'(KEY_ADDR));
        dis_d     = ctrl_take ? wr_word.dis : dis_q;
        run       = (state_q == WD_RUN);
    end

    // control word fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q   <= '0;
            dis_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_take) begin
                ps_q  <= wr_word.ps;
                dis_q <= wr_word.dis;
            end
            if (ovf)                            flag_q <= 1'b1;
            else if (ctrl_take && wr_word.flag) flag_q <= 1'b0;
        end
    end

    wdk_prescaler #(.BASE_DIV(BASE_DIV), .PS_W(3)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(service), .ps(ps_q), .tick(tick)
    );

    wdk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(service), .tick(tick),
        .ovf(ovf), .cnt(cnt_q)
    );

    wdk_key_fsm u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data), .service(service)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        if (ctrl_bad) begin
            state_d = WD_BITE;
            hold_d  = '0;
        end else begin
            unique case (state_q)
                WD_RUN: begin
                    if (ovf) begin
                        state_d = WD_BITE;
                        hold_d  = '0;
                    end else if (ctrl_take && wr_word.dis) begin
                        state_d = WD_OFF;
                    end
                end
                WD_OFF: begin
                    if (ctrl_take && !wr_word.dis) state_d = WD_RUN;
                end
                WD_BITE: begin
                    if (hold_q == HOLD_LAST) state_d = dis_d ? WD_OFF : WD_RUN;
                    else                     hold_d  = hold_q + HOLD_W'(1);
                end
                default: state_d = WD_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        wd_reset = (state_q == WD_BITE);
        wd_flag  = flag_q;
    end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int CNT_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              prot_lift,
    input logic              wd_reset,
    input logic              wd_flag,
    input logic [1:0]        st,
    input logic [CNT_W-1:0]  cnt
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    AST_BADKEY_BITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && prot_lift && (wr_data[5:3] != 3'b101)) |=> wd_reset); // R3
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset) |=> wd_reset); // R3
    AST_FLAG_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> wd_reset); // R5
    AST_FLAG_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_flag) |-> $past(ctl_wr && prot_lift && (wr_data[5:3] == 3'b101) && wr_data[7])); // R7
    AST_PROT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && ctl_wr && !prot_lift) |=> wd_flag); // R2
    AST_OFF_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd1) |=> (cnt == '0)); // R6
endmodule

bind keyed_wdog keyed_wdog_chk #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prot_lift(prot_lift), .wd_reset(wd_reset), .wd_flag(wd_flag),
    .st(state_q), .cnt(cnt_q)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
    localparam int BD   = 2;
    localparam int CW   = 4;
    localparam int WRAP = 1 << CW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       prot_lift = 1'b0;
    logic       wd_reset, wd_flag;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    keyed_wdog #(.BASE_DIV(BD), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_lift(prot_lift), .wd_reset(wd_reset), .wd_flag(wd_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic p);
        wr_en = 1'b1; wr_addr = a; wr_data = d; prot_lift = p;
        @(negedge clk);
        wr_en = 1'b0; prot_lift = 1'b0;
    endtask

    function automatic logic [7:0] cw(input bit f, input bit dis, input logic [2:0] c, input logic [2:0] ps);
        return {f, dis, c, ps};
    endfunction

    task automatic service();
        wr(2'd1, 8'h55, 1'b0);
        wr(2'd1, 8'hAA, 1'b0);
    endtask

    task automatic expect_bite_at(input int n, input string tag);
        cyc(n - 1);
        chk(wd_reset == 1'b0, tag, int'(wd_reset), 0);
        cyc(1);
        chk(wd_reset == 1'b1, tag, int'(wd_reset), 1);
    endtask

    task automatic measure_pulse(input string tag, input int exp);
        int n = 0;
        while (wd_reset && n < 40) begin
            n++;
            cyc(1);
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk(wd_reset == 1'b0, "R1 reset output", int'(wd_reset), 0);
        chk(wd_flag == 1'b0, "R1 flag at reset", int'(wd_flag), 0);
        expect_bite_at(BD * WRAP, "R1 default enabled code0");
        chk(wd_flag == 1'b1, "R5 flag with pulse", int'(wd_flag), 1);
        measure_pulse("R5 overflow pulse width", 8);
        expect_bite_at(BD * WRAP, "R5 restart after pulse");
    endtask

    task automatic t_prescale(input logic [2:0] code);
        int per = (code == 0) ? BD : BD << (code - 1);
        do_reset();
        wr(2'd0, cw(0, 0, 3'b101, code), 1'b1);
        service();
        expect_bite_at(per * WRAP, $sformatf("R4 prescale code %0d", code));
    endtask

    task automatic t_protect();
        do_reset();
        wr(2'd0, cw(0, 1, 3'b101, 3'd3), 1'b0);
        wr(2'd0, cw(0, 0, 3'b000, 3'd0), 1'b0);
        chk(wd_reset == 1'b0, "R2 protected bad write no reset", int'(wd_reset), 0);
        service();
        expect_bite_at(BD * WRAP, "R2 protected write ignored");
    endtask

    task automatic t_badkey();
        do_reset();
        wr(2'd0, cw(0, 0, 3'b100, 3'd2), 1'b1);
        chk(wd_reset == 1'b1, "R3 bad pattern fires", int'(wd_reset), 1);
        measure_pulse("R3 bad pattern pulse width", 8);
        expect_bite_at(BD * WRAP, "R3 control unchanged");
        chk(wd_flag == 1'b1, "R5 flag on overflow", int'(wd_flag), 1);
    endtask

    task automatic t_retrigger();
        do_reset();
        wr(2'd0, 8'h00, 1'b1);
        cyc(3);
        wr(2'd0, 8'h00, 1'b1);
        measure_pulse("R9 retrigger restarts window", 8);
    endtask

    task automatic t_flag();
        do_reset();
        expect_bite_at(BD * WRAP, "R5 overflow");
        measure_pulse("R5 pulse", 8);
        wr(2'd0, cw(1, 0, 3'b101, 3'd0), 1'b0);
        chk(wd_flag == 1'b1, "R2 protected flag clear ignored", int'(wd_flag), 1);
        wr(2'd0, cw(0, 0, 3'b101, 3'd0), 1'b1);
        chk(wd_flag == 1'b1, "R7 write 0 keeps flag", int'(wd_flag), 1);
        wr(2'd0, cw(1, 0, 3'b101, 3'd0), 1'b1);
        chk(wd_flag == 1'b0, "R7 write 1 clears flag", int'(wd_flag), 0);
    endtask

    task automatic t_disable();
        int seen = 0;
        do_reset();
        wr(2'd0, cw(0, 1, 3'b101, 3'd0), 1'b1);
        for (int i = 0; i < 6 * BD * WRAP; i++) begin
            if (wd_reset || wd_flag) seen++;
            cyc(1);
        end
        chk(seen == 0, "R6 disabled no overflow", seen, 0);
        wr(2'd0, cw(0, 0, 3'b101, 3'd0), 1'b1);
        expect_bite_at(BD * WRAP, "R6 resume from zero");
    endtask

    task automatic t_service();
        do_reset();
        cyc(20);
        service();
        expect_bite_at(BD * WRAP, "R8 key pair clears");
        do_reset();
        cyc(10);
        wr(2'd1, 8'hAA, 1'b0);
        expect_bite_at(BD * WRAP - 11, "R8 lone second key ignored");
        do_reset();
        wr(2'd1, 8'h55, 1'b0);
        wr(2'd1, 8'h12, 1'b0);
        wr(2'd1, 8'hAA, 1'b0);
        expect_bite_at(BD * WRAP - 3, "R8 broken sequence ignored");
        do_reset();
        cyc(5);
        wr(2'd1, 8'h55, 1'b0);
        wr(2'd1, 8'h55, 1'b0);
        wr(2'd1, 8'hAA, 1'b0);
        expect_bite_at(BD * WRAP, "R8 repeated first key stays armed");
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_prescale(3'd0);
        t_prescale(3'd1);
        t_prescale(3'd2);
        t_prescale(3'd3);
        t_prescale(3'd7);
        t_protect();
        t_badkey();
        t_retrigger();
        t_flag();
        t_disable();
        t_service();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        tests++;
        fails++;
        $display("[TB] FAIL watchdog timeout actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule